// File: doc/BRIEF.md
# Tagged Read Request Issuer

This block takes a single transfer command and moves that many dwords from a host address space into a local memory. It does this by emitting a stream of memory read requests toward the host link. Each request carries an address, a dword count and a tag. The block keeps several requests in flight at once, so the link round trip is overlapped rather than paid once per request. The size of each request is limited by a 3-bit maximum-read-size code.

Completion data comes back as one dword per beat, labelled with the tag of the request it answers. Beats may arrive out of request order, and a single request may be answered in several pieces. The block turns each beat into a local write. The write address is taken from the tag's destination base plus the number of dwords already received for that tag. A tag goes back to the pool once its last dword has arrived. When all requests are issued and every tag is back in the pool, a one-cycle done pulse ends the command.

Top module: `tagged_read_issuer`

## Requirements
- R1: `cmd_ready` is high only while idle. A command is taken on `cmd_valid && cmd_ready`. A `cmd_valid` raised while a transfer runs has no effect on the requests, writes or done of the running transfer.
- R2: The first request is offered in the cycle after a command is accepted. Further requests follow without waiting for any completion, until all `NUM_TAGS` tags are in flight.
- R3: The number of requests in flight never exceeds `NUM_TAGS`, and a tag is never handed out while still in flight.
- R4: Each request length in dwords is the smaller of the remaining dwords and `32 << min(code, 5)`. Here `code` is `mrrs_code` sampled at command acceptance, so codes 0 to 5 give 128 to 4096 bytes and codes 6 and 7 behave as 5.
- R5: The address of each request is the command source address plus 4 times the dwords already requested for this command.
- R6: Tags are given out in strict rotation 0, 1, ..., `NUM_TAGS-1`, 0, ... The rotation continues across commands, and issue waits while the next tag in the rotation is still in flight.
- R7: Each completion beat produces, one cycle later, `wr_en` with unchanged data. `wr_addr` is the command destination address plus the byte offset of that dword within the whole transfer, whatever the arrival order or split of the completions.
- R8: A tag returns to the pool only after all dwords of its request have been received. Until then it blocks further issue.
- R9: `done` is a single-cycle pulse raised after every request has been issued and every tag has returned. By then all dwords of the transfer have been written, and `cmd_ready` is high again from the following cycle.
- R10: After reset, `cmd_ready` is 1 and `req_valid`, `wr_en` and `done` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cmd_valid | input | 1 | Command offered |
| cmd_ready | output | 1 | Block idle, command will be taken |
| cmd_src | input | 32 | Host byte address of the data, dword aligned |
| cmd_dst | input | 32 | Local byte address for the data |
| cmd_len | input | 13 | Transfer length in dwords |
| mrrs_code | input | 3 | Maximum read request size code |
| req_valid | output | 1 | Read request offered |
| req_ready | input | 1 | Link takes the request |
| req_addr | output | 32 | Request host byte address |
| req_len | output | 13 | Request length in dwords |
| req_tag | output | 2 | Request tag |
| cpl_valid | input | 1 | Completion data beat present |
| cpl_tag | input | 2 | Tag of the beat |
| cpl_data | input | 32 | One dword of completion data |
| wr_en | output | 1 | Local memory write strobe |
| wr_addr | output | 32 | Local byte address of the write |
| wr_data | output | 32 | Write data |
| done | output | 1 | Command complete pulse |

## Verification
The assertions rely on the link behaving correctly. Completion beats arrive only for tags that are in flight, and never more dwords than the request asked for. Commands carry a nonzero length of at most 4096 dwords and a dword-aligned source. The bench answers only requests it has seen on the request port, and it sends exactly the requested number of beats for each. It answers each batch of in-flight requests newest first, splitting them into 64-dword pieces, so that out-of-order and split arrival are exercised within those limits. Each beat's data is its own source address, which lets every write be checked against the destination mapping without any knowledge of tags.

// File: rtl/trd_pkg.sv
// Shared helpers for the tagged read issuer.
// Assumes: request-size codes above 5 are treated as code 5.
package trd_pkg;
    localparam int MAX_CODE = 5;

    // Convert a read-size code to a request limit in dwords (128 bytes << code).
    function automatic int unsigned code_to_dw(input logic [2:0] code);
        int unsigned c;
        c = (int'(code) > MAX_CODE) ? MAX_CODE : int'(code);
        return 32 << c;
    endfunction
endpackage

// File: rtl/trd_splitter.sv
// Accepts a command and cuts it into read requests no longer than the size limit.
// Assumes: cmd_len <= 4096 dwords, cmd_src is dword aligned, the tag pool reports
// whether the next tag in rotation is free and whether all tags are free.
module trd_splitter #(
    parameter int ADDR_W = 32,
    parameter int LEN_W  = 13
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cmd_valid,
    output logic              cmd_ready,
    input  logic [ADDR_W-1:0] cmd_src,
    input  logic [ADDR_W-1:0] cmd_dst,
    input  logic [LEN_W-1:0]  cmd_len,
    input  logic [2:0]        mrrs_code,
    output logic              req_valid,
    input  logic              req_ready,
    output logic [ADDR_W-1:0] req_addr,
    output logic [LEN_W-1:0]  req_len,
    input  logic              slot_free,
    input  logic              all_free,
    output logic              issue,
    output logic [ADDR_W-1:0] issue_dst,
    output logic              done
);
    logic              busy_q;
    logic [LEN_W-1:0]  rem_q;
    logic [LEN_W-1:0]  max_dw_q;
    logic [ADDR_W-1:0] src_q;
    logic [ADDR_W-1:0] dst_q;
    logic [ADDR_W-1:0] step_bytes;

    assign cmd_ready  = !busy_q;
    assign req_valid  = busy_q && (rem_q != '0) && slot_free;
    // Clip the next request to the size limit.
    always_comb req_len = (rem_q < max_dw_q) ? rem_q : max_dw_q;
    assign req_addr   = src_q;
    assign issue      = req_valid && req_ready;
    assign issue_dst  = dst_q;
    assign step_bytes = ADDR_W'({req_len, 2'b00});

    // Command capture, address walk and completion detection.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            busy_q   <= 1'b0;
            rem_q    <= '0;
            max_dw_q <= '0;
            src_q    <= '0;
            dst_q    <= '0;
            done     <= 1'b0;
        end else begin
            done <= 1'b0;
            if (!busy_q) begin
                if (cmd_valid) begin
                    busy_q   <= 1'b1;
                    rem_q    <= cmd_len;
                    max_dw_q <= LEN_W'(trd_pkg::code_to_dw(mrrs_code));
                    src_q    <= cmd_src;
                    dst_q    <= cmd_dst;
                end
            end else if (issue) begin
                rem_q <= rem_q - req_len;
                src_q <= src_q + step_bytes;
                dst_q <= dst_q + step_bytes;
            end else if (rem_q == '0 && all_free) begin
                busy_q <= 1'b0;
                done   <= 1'b1;
            end
        end
    end

    assert_first_req_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_valid && cmd_ready) |=> req_valid);
    assert_req_cap_R4: assert property (@(posedge clk) disable iff (!rst_n)
        req_valid |-> (req_len != '0 && req_len <= max_dw_q));
    assert_busy_locked_R1: assert property (@(posedge clk) disable iff (!rst_n)
        busy_q |=> $stable(max_dw_q));
    assert_done_clean_R9: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> (all_free && cmd_ready && !req_valid));
endmodule

// File: rtl/trd_tag_pool.sv
// Holds per-tag state: in-flight flag, requested and received dword counts and the
// local base address. Hands tags out in strict rotation and frees a tag on its last beat.
// Assumes: completion beats only name tags in flight and never exceed the request.
module trd_tag_pool #(
    parameter int NUM_TAGS = 4,
    parameter int ADDR_W   = 32,
    parameter int LEN_W    = 13,
    localparam int TAG_W   = (NUM_TAGS > 1) ? $clog2(NUM_TAGS) : 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              issue,
    input  logic [ADDR_W-1:0] issue_dst,
    input  logic [LEN_W-1:0]  issue_len,
    output logic [TAG_W-1:0]  next_tag,
    output logic              slot_free,
    output logic              all_free,
    input  logic              cpl_valid,
    input  logic [TAG_W-1:0]  cpl_tag,
    output logic [ADDR_W-1:0] beat_addr
);
    logic [NUM_TAGS-1:0] live_q;
    logic [LEN_W-1:0]    want_q [NUM_TAGS];
    logic [LEN_W-1:0]    got_q  [NUM_TAGS];
    logic [ADDR_W-1:0]   base_q [NUM_TAGS];
    logic [TAG_W-1:0]    ptr_q;
    logic                last_beat;

    assign next_tag  = ptr_q;
    assign slot_free = !live_q[ptr_q];
    assign all_free  = (live_q == '0);
    assign last_beat = (got_q[cpl_tag] + LEN_W'(1)) == want_q[cpl_tag];
    assign beat_addr = base_q[cpl_tag] + ADDR_W'({got_q[cpl_tag], 2'b00});

    // Allocate at the rotation pointer, count beats, release on the final beat.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            live_q <= '0;
            ptr_q  <= '0;
            for (int i = 0; i < NUM_TAGS; i++) begin
                want_q[i] <= '0;
                got_q[i]  <= '0;
                base_q[i] <= '0;
            end
        end else begin
            if (issue) begin
                live_q[ptr_q] <= 1'b1;
                want_q[ptr_q] <= issue_len;
                got_q[ptr_q]  <= '0;
                base_q[ptr_q] <= issue_dst;
                ptr_q <= (ptr_q == TAG_W'(NUM_TAGS - 1)) ? '0 : ptr_q + TAG_W'(1);
            end
            if (cpl_valid) begin
                if (last_beat) begin
                    live_q[cpl_tag] <= 1'b0;
                    got_q[cpl_tag]  <= '0;
                end else begin
                    got_q[cpl_tag] <= got_q[cpl_tag] + LEN_W'(1);
                end
            end
        end
    end

    assert_tag_unused_R3: assert property (@(posedge clk) disable iff (!rst_n)
        issue |-> !live_q[ptr_q]);
    assert_cpl_live_R8: assert property (@(posedge clk) disable iff (!rst_n)
        cpl_valid |-> live_q[cpl_tag]);
    assert_rotate_R6: assert property (@(posedge clk) disable iff (!rst_n)
        issue |=> (ptr_q != $past(ptr_q) || NUM_TAGS == 1));

    genvar g;
    generate
        for (g = 0; g < NUM_TAGS; g++) begin : g_tag_chk
            assert_count_bound_R8: assert property (@(posedge clk) disable iff (!rst_n)
                live_q[g] |-> (got_q[g] < want_q[g]));
        end
    endgenerate
endmodule

// File: rtl/trd_cpl_writer.sv
// Registers one local memory write per completion beat.
// Assumes: the beat address has been resolved by the tag pool in the same cycle.
module trd_cpl_writer #(
    parameter int ADDR_W = 32,
    parameter int DATA_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cpl_valid,
    input  logic [DATA_W-1:0] cpl_data,
    input  logic [ADDR_W-1:0] beat_addr,
    output logic              wr_en,
    output logic [ADDR_W-1:0] wr_addr,
    output logic [DATA_W-1:0] wr_data
);
    // Stage the write strobe, address and data.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wr_en   <= 1'b0;
            wr_addr <= '0;
            wr_data <= '0;
        end else begin
            wr_en <= cpl_valid;
            if (cpl_valid) begin
                wr_addr <= beat_addr;
                wr_data <= cpl_data;
            end
        end
    end
endmodule

// File: rtl/tagged_read_issuer.sv
// Top: splits a transfer command into tagged read requests, keeps up to NUM_TAGS in
// flight, and writes the returning completion dwords into local memory.
// Assumes: link returns each request's dwords in order within a tag, in any tag order.
module tagged_read_issuer #(
    parameter int NUM_TAGS = 4,
    parameter int ADDR_W   = 32,
    parameter int LEN_W    = 13,
    parameter int DATA_W   = 32,
    localparam int TAG_W   = (NUM_TAGS > 1) ? $clog2(NUM_TAGS) : 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cmd_valid,
    output logic              cmd_ready,
    input  logic [ADDR_W-1:0] cmd_src,
    input  logic [ADDR_W-1:0] cmd_dst,
    input  logic [LEN_W-1:0]  cmd_len,
    input  logic [2:0]        mrrs_code,
    output logic              req_valid,
    input  logic              req_ready,
    output logic [ADDR_W-1:0] req_addr,
    output logic [LEN_W-1:0]  req_len,
    output logic [TAG_W-1:0]  req_tag,
    input  logic              cpl_valid,
    input  logic [TAG_W-1:0]  cpl_tag,
    input  logic [DATA_W-1:0] cpl_data,
    output logic              wr_en,
    output logic [ADDR_W-1:0] wr_addr,
    output logic [DATA_W-1:0] wr_data,
    output logic              done
);
    logic              slot_free;
    logic              all_free;
    logic              issue;
    logic [ADDR_W-1:0] issue_dst;
    logic [ADDR_W-1:0] beat_addr;

    trd_splitter #(.ADDR_W(ADDR_W), .LEN_W(LEN_W)) u_split (
        .clk(clk), .rst_n(rst_n),
        .cmd_valid(cmd_valid), .cmd_ready(cmd_ready),
        .cmd_src(cmd_src), .cmd_dst(cmd_dst), .cmd_len(cmd_len), .mrrs_code(mrrs_code),
        .req_valid(req_valid), .req_ready(req_ready), .req_addr(req_addr), .req_len(req_len),
        .slot_free(slot_free), .all_free(all_free),
        .issue(issue), .issue_dst(issue_dst), .done(done)
    );

    trd_tag_pool #(.NUM_TAGS(NUM_TAGS), .ADDR_W(ADDR_W), .LEN_W(LEN_W)) u_pool (
        .clk(clk), .rst_n(rst_n),
        .issue(issue), .issue_dst(issue_dst), .issue_len(req_len),
        .next_tag(req_tag), .slot_free(slot_free), .all_free(all_free),
        .cpl_valid(cpl_valid), .cpl_tag(cpl_tag), .beat_addr(beat_addr)
    );

    trd_cpl_writer #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_wr (
        .clk(clk), .rst_n(rst_n),
        .cpl_valid(cpl_valid), .cpl_data(cpl_data), .beat_addr(beat_addr),
        .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data)
    );

    assert_write_after_beat_R7: assert property (@(posedge clk) disable iff (!rst_n)
        cpl_valid |=> wr_en);
    assert_no_req_idle_R1: assert property (@(posedge clk) disable iff (!rst_n)
        cmd_ready |-> !req_valid);
endmodule

// File: tb/sim_tagged_read_issuer.sv
`timescale 1ns/1ps
module sim_tagged_read_issuer;
    localparam int NT = 4;
    localparam int NV = 5;
    localparam int VSRC  [NV] = '{32'h0000_1000, 32'h0002_0004, 32'h0010_0000, 32'h0030_0040, 32'h0040_0000};
    localparam int VDST  [NV] = '{32'h0800_0000, 32'h0801_0000, 32'h0802_0000, 32'h0806_0100, 32'h0808_0000};
    localparam int VLEN  [NV] = '{256, 1000, 4096, 300, 4096};
    localparam int VCODE [NV] = '{0, 2, 5, 1, 7};

    logic clk = 0, rst_n = 0;
    logic cmd_valid = 0, req_ready = 0, cpl_valid = 0;
    logic cmd_ready, req_valid, wr_en, done;
    logic [31:0] cmd_src = 0, cmd_dst = 0, req_addr, wr_addr, wr_data, cpl_data = 0;
    logic [12:0] cmd_len = 0, req_len;
    logic [2:0] mrrs_code = 0;
    logic [1:0] req_tag, cpl_tag = 0;

    tagged_read_issuer u0 (.*);

    always #2.5 clk = ~clk;

    int n_chk = 0, n_fail = 0;
    int r_addr [512], r_len [512], r_tag [512], r_got [512];
    int cap_n = 0, tag_ctr = 0, issued = 0, writes = 0, done_cnt = 0, outst = 0;
    int e_src = 0, e_dst = 0, e_len = 0, e_code = 0;

    task automatic check(input bit ok, input string req, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    function automatic int cap_dw(input int code);
        return 32 << ((code > 5) ? 5 : code);
    endfunction

    // Monitor: requests, writes, done
    always @(negedge clk) begin
        if (rst_n) begin
            if (req_valid && req_ready) begin
                int rest, want;
                rest = e_len - issued;
                want = (rest < cap_dw(e_code)) ? rest : cap_dw(e_code);
                check(int'(req_len) == want, "R4 req_len", int'(req_len), want);
                check(req_addr == 32'(e_src + 4 * issued), "R5 req_addr", int'(req_addr), e_src + 4 * issued);
                check(int'(req_tag) == tag_ctr % NT, "R6 req_tag", int'(req_tag), tag_ctr % NT);
                check(outst < NT, "R3 outstanding", outst + 1, NT);
                r_addr[cap_n] = int'(req_addr);
                r_len[cap_n] = int'(req_len);
                r_tag[cap_n] = int'(req_tag);
                r_got[cap_n] = 0;
                cap_n++; tag_ctr++; outst++;
                issued += int'(req_len);
            end
            if (wr_en) begin
                check(wr_addr == 32'(e_dst) + (wr_data - 32'(e_src)), "R7 wr_addr",
                      int'(wr_addr), int'(32'(e_dst) + (wr_data - 32'(e_src))));
                writes++;
            end
            if (done) begin
                done_cnt++;
                check(writes == e_len, "R9 writes before done", writes, e_len);
            end
        end
    end

    task automatic beat(input int i);
        @(negedge clk);
        cpl_valid = 1;
        cpl_tag   = 2'(r_tag[i]);
        cpl_data  = 32'(r_addr[i] + 4 * r_got[i]);
        r_got[i]++;
        if (r_got[i] == r_len[i]) outst--;
    endtask

    task automatic idle();
        @(negedge clk);
        cpl_valid = 0;
    endtask

    // Send the remaining dwords of request i in 64-dword pieces.
    task automatic serve(input int i);
        while (r_got[i] < r_len[i]) begin
            beat(i);
            if (r_got[i] % 64 == 0) idle();
        end
        idle();
    endtask

    task automatic run_cmd(input int src, input int dst, input int len, input int code,
                           input bit poke, input bit hold);
        int base, nreq, ans, hi;
        @(negedge clk);
        e_src = src; e_dst = dst; e_len = len; e_code = code;
        issued = 0; writes = 0; done_cnt = 0; base = cap_n;
        nreq = (len + cap_dw(code) - 1) / cap_dw(code);
        cmd_src = 32'(src); cmd_dst = 32'(dst); cmd_len = 13'(len); mrrs_code = 3'(code);
        cmd_valid = 1;
        @(negedge clk);
        cmd_valid = 0;
        check(cmd_ready == 0, "R1 busy after accept", int'(cmd_ready), 0);
        if (poke) begin
            cmd_src = 32'h0BAD_0000; cmd_dst = 32'h0F00_0000; cmd_len = 13'd7; mrrs_code = 3'd0;
            cmd_valid = 1;
            @(negedge clk);
            check(cmd_ready == 0, "R1 ignore while busy", int'(cmd_ready), 0);
            cmd_valid = 0;
        end
        repeat (6) @(negedge clk);
        check(cap_n - base == ((nreq < NT) ? nreq : NT), "R2 pipelined issue", cap_n - base,
              (nreq < NT) ? nreq : NT);
        if (hold) begin
            while (r_got[base] < r_len[base] - 1) beat(base);
            idle();
            repeat (5) @(negedge clk);
            check(cap_n - base == NT, "R8 tag held until last dword", cap_n - base, NT);
            beat(base);
            idle();
            repeat (2) @(negedge clk);
            check(cap_n - base == NT + 1, "R8 tag freed on last dword", cap_n - base, NT + 1);
        end
        ans = base;
        while (ans < base + nreq) begin
            repeat (4) @(negedge clk);
            hi = cap_n;
            for (int i = hi - 1; i >= ans; i--) serve(i);
            ans = hi;
        end
        for (int k = 0; k < 20 && done_cnt == 0; k++) @(negedge clk);
        @(negedge clk);
        check(done_cnt == 1, "R9 done pulse count", done_cnt, 1);
        check(cmd_ready == 1, "R9 ready after done", int'(cmd_ready), 1);
        check(cap_n - base == nreq, "R4 request count", cap_n - base, nreq);
        check(writes == len, "R7 write count", writes, len);
    endtask

    // Watchdog
    initial begin
        repeat (150000) @(posedge clk);
        n_chk++; n_fail++;
        $display("FAIL watchdog expired actual=running expected=finished");
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        check(cmd_ready == 1, "R10 reset cmd_ready", int'(cmd_ready), 1);
        check(req_valid == 0, "R10 reset req_valid", int'(req_valid), 0);
        check(wr_en == 0, "R10 reset wr_en", int'(wr_en), 0);
        check(done == 0, "R10 reset done", int'(done), 0);
        rst_n = 1;
        req_ready = 1;
        @(negedge clk);
        check(req_valid == 0 && cmd_ready == 1, "R10 idle after reset", int'(req_valid), 0);
        for (int v = 0; v < NV; v++) run_cmd(VSRC[v], VDST[v], VLEN[v], VCODE[v], 0, 0);
        // Directed: split completion holds the oldest tag (R8)
        run_cmd(32'h0050_0000, 32'h080A_0000, 512, 0, 0, 1);
        // Directed: command offered while busy is ignored (R1)
        run_cmd(32'h0060_0010, 32'h080C_0000, 2048, 3, 1, 0);
        repeat (5) @(negedge clk);
        check(req_valid == 0 && wr_en == 0, "R1 no stray activity", int'(req_valid), 0);
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end
endmodule